// File: doc/BRIEF.md
# Link Mode Negotiation Resolver with Break-Link Restart

This block settles the operating mode of an Ethernet copper port once the abilities of both link ends are known. When the link partner negotiates, the block takes the highest mode that both ends list and reports it as a speed code and a duplex flag. When the partner does not negotiate but a 10 Mb/s or 100 Mb/s receiver reports a valid link, the block completes by parallel detection. In that case it builds the partner ability word itself and flags any case where more than one receiver claims a link.

A restart request, a negotiation with no shared mode, a parallel-detect fault, or loss of a link that was up all send the block into a break-link interval. During this interval transmit and link pulses are held silent. The interval is measured with a prescaled millisecond tick, so a chip sets it near 1.5 s and a bench can shorten it. The block also forms the local base word that carries the local abilities and the two local pause bits out to the partner. It does not resolve pause.

Top module: `an_resolve_ctrl`

## Requirements
- R1: Ability vectors use bit 5 = 1000 full, 4 = 1000 half, 3 = 100 full, 2 = 100 half, 1 = 10 full, 0 = 10 half. When `lp_valid` is seen while listening, the block completes on the highest bit set in both `adv_abil` and `lp_abil`. It reports `speed` as 2 for 1000, 1 for 100 and 0 for 10, and `full_dup` as the duplex of that mode, one clock later.
- R2: When `lp_valid` is seen while listening and no bit is common, `an_done` stays 0 and `tx_quiet` is 1 from the next clock.
- R3: On a negotiated completion, `lp_an_able` is 1 and `lp_word_wr` pulses. `lp_word` holds selector 00001 in bits 4:0, `lp_abil[3:0]` in bits 8:5, and zeros elsewhere.
- R4: With `lp_valid` low and exactly one of `pd_link10`/`pd_link100` high while listening, the block completes at that speed in half duplex. `lp_an_able` is 0, and `lp_word` is 0x0021 for 10 Mb/s or 0x0081 for 100 Mb/s.
- R5: Both parallel-detect links high while listening sets `pd_fault` and enters the silent interval. `pd_fault` stays set until a `restart_req` clears it on the next clock.
- R6: `restart_req` in any state makes `tx_quiet` 1 from the next clock. `tx_quiet` then holds for exactly TICK_DIV*QUIET_MS clocks, after which listening resumes. `an_done` and `link_up` are 0 throughout.
- R7: Once `link_up` is 1, a low `link_ok` drops `link_up` and raises `tx_quiet` on the next clock.
- R8: `link_up` becomes 1 only when the block has completed, one clock after `link_ok` is high. It stays 0 while listening, whatever `link_ok` is.
- R9: `tx_base_word` is registered. It holds 00001 in bits 4:0, `adv_abil[3:0]` in bits 8:5, `adv_pause` in bits 11:10, and zeros elsewhere.
- R10: During reset, `an_done`, `tx_quiet`, `link_up`, `pd_fault` and `lp_word_wr` are 0, and the block starts listening.
- R11: When `lp_valid` and a parallel-detect link are high together, the negotiated result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv_abil | input | 6 | Local advertised modes |
| adv_pause | input | 2 | Local pause and asymmetric pause abilities |
| lp_abil | input | 6 | Partner advertised modes |
| lp_valid | input | 1 | Partner page received, partner negotiates |
| pd_link10 | input | 1 | 10 Mb/s receiver reports valid link |
| pd_link100 | input | 1 | 100 Mb/s receiver reports valid link |
| link_ok | input | 1 | Link status from the active receiver |
| restart_req | input | 1 | Request to restart negotiation |
| speed | output | 2 | Resolved speed code |
| full_dup | output | 1 | Resolved duplex |
| an_done | output | 1 | Negotiation complete |
| link_up | output | 1 | Link status flag |
| pd_fault | output | 1 | Parallel-detect fault flag |
| lp_an_able | output | 1 | Partner negotiated (0 after parallel detection) |
| lp_word | output | 16 | Partner ability word |
| lp_word_wr | output | 1 | One-clock update strobe for `lp_word` |
| tx_base_word | output | 16 | Local base word sent to the partner |
| tx_quiet | output | 1 | Transmit and link pulses silenced |

## Verification
A wrong state register shows up at the ports within one clock. `an_done`, `tx_quiet` and `link_up` each follow the state that the transition edge entered. A wrong priority pick shows up at that same edge as the wrong `speed` or `full_dup`. A break-link counter that is off by even one tick changes how long `tx_quiet` stays high, so the bench counts those cycles. A fault flag that is not sticky, or a partner word that is built wrongly, is caught at the first completion or listening phase that follows.

// File: rtl/an_res_pkg.sv
// Package: shared state type and word-building helpers for the mode resolver.
// Assumes the ability vector ordering in which bit index encodes speed (idx>>1)
// and duplex (idx[0]).
package an_res_pkg;

    typedef enum logic [1:0] {
        ST_LISTEN = 2'd0,
        ST_QUIET  = 2'd1,
        ST_DONE   = 2'd2
    } an_state_e;

    localparam int          N_MODES  = 6;
    localparam logic [4:0]  SEL_8023 = 5'b00001;

    // Builds a base word: selector, four 10/100 ability bits, pause pair.
    function automatic logic [15:0] base_word(input logic [3:0] abil,
                                              input logic [1:0] pause);
        base_word = {4'b0000, pause, 1'b0, abil, SEL_8023};
    endfunction

endpackage

// File: rtl/an_prio_pick.sv
// Priority picker: finds the highest mode bit advertised by both ends.
// Assumes a higher bit index means a higher-priority mode.
module an_prio_pick #(
    parameter int N  = 6,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  adv,
    input  logic [N-1:0]  lp,
    output logic          found,
    output logic [IW-1:0] idx
);
    logic [N-1:0] common;

    assign common = adv & lp;
    assign found  = |common;

    // Ascending scan so the last hit, the highest index, wins.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (common[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/an_pd_eval.sv
// Parallel-detect evaluator: classifies the 10/100 receiver link reports and
// synthesises the partner ability word for a single good link.
// Assumes both inputs are already synchronous to clk.
module an_pd_eval (
    input  logic        pd10,
    input  logic        pd100,
    output logic        single,
    output logic        multi,
    output logic [1:0]  pd_speed,
    output logic [15:0] pd_word
);
    import an_res_pkg::*;

    assign single   = pd10 ^ pd100;
    assign multi    = pd10 & pd100;
    assign pd_speed = pd100 ? 2'd1 : 2'd0;

    // Word: selector plus the half-duplex bit of the detected technology.
    always_comb begin
        pd_word      = {11'b0, SEL_8023};
        pd_word[5]   = pd10 & ~pd100;
        pd_word[7]   = pd100 & ~pd10;
    end
endmodule

// File: rtl/an_brk_timer.sv
// Break-link timer: a prescaler makes a millisecond tick, a second counter
// counts QUIET_MS ticks. expire pulses in the last cycle of the interval.
// Assumes clr is held while the interval is not running.
module an_brk_timer #(
    parameter int TICK_DIV = 125000,
    parameter int QUIET_MS = 1500,
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1,
    localparam int MW = $clog2(QUIET_MS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expire
);
    logic [PW-1:0] pre_q;
    logic [MW-1:0] ms_q;
    logic          tick;

    assign tick   = (pre_q == PW'(TICK_DIV - 1));
    assign expire = tick && (ms_q == MW'(QUIET_MS - 1));

    // Prescaler and millisecond counter, both cleared while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (tick) begin
            pre_q <= '0;
            ms_q  <= expire ? '0 : ms_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R6
    ms_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ms_q < MW'(QUIET_MS));
endmodule

// File: rtl/an_resolve_ctrl.sv
// Negotiation resolver and restart controller. Listens for a partner page or a
// parallel-detect link, completes with the resolved mode, supervises the link
// and silences transmit for a break-link interval on any restart cause.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module an_resolve_ctrl #(
    parameter int TICK_DIV = 125000,
    parameter int QUIET_MS = 1500
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  adv_abil,
    input  logic [1:0]  adv_pause,
    input  logic [5:0]  lp_abil,
    input  logic        lp_valid,
    input  logic        pd_link10,
    input  logic        pd_link100,
    input  logic        link_ok,
    input  logic        restart_req,
    output logic [1:0]  speed,
    output logic        full_dup,
    output logic        an_done,
    output logic        link_up,
    output logic        pd_fault,
    output logic        lp_an_able,
    output logic [15:0] lp_word,
    output logic        lp_word_wr,
    output logic [15:0] tx_base_word,
    output logic        tx_quiet
);
    import an_res_pkg::*;

    localparam int IW = $clog2(N_MODES);

    an_state_e     st_q;
    logic          res_found;
    logic [IW-1:0] res_idx;
    logic          pd_single, pd_multi;
    logic [1:0]    pd_speed;
    logic [15:0]   pd_word;
    logic          brk_expire;
    logic          tmr_clr;

    an_prio_pick #(.N(N_MODES)) u_pick (
        .adv   (adv_abil),
        .lp    (lp_abil),
        .found (res_found),
        .idx   (res_idx)
    );

    an_pd_eval u_pd (
        .pd10     (pd_link10),
        .pd100    (pd_link100),
        .single   (pd_single),
        .multi    (pd_multi),
        .pd_speed (pd_speed),
        .pd_word  (pd_word)
    );

    assign tmr_clr = (st_q != ST_QUIET) || restart_req;

    an_brk_timer #(.TICK_DIV(TICK_DIV), .QUIET_MS(QUIET_MS)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .expire (brk_expire)
    );

    assign an_done  = (st_q == ST_DONE);
    assign tx_quiet = (st_q == ST_QUIET);

    // State sequencing plus the result registers written on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_LISTEN;
            speed      <= 2'd0;
            full_dup   <= 1'b0;
            pd_fault   <= 1'b0;
            lp_an_able <= 1'b0;
            lp_word    <= 16'h0000;
            lp_word_wr <= 1'b0;
        end else begin
            lp_word_wr <= 1'b0;
            if (restart_req) begin
                st_q     <= ST_QUIET;
                pd_fault <= 1'b0;
            end else begin
                case (st_q)
                    ST_LISTEN: begin
                        if (lp_valid) begin
                            if (res_found) begin
                                st_q       <= ST_DONE;
                                speed      <= res_idx[IW-1:1];
                                full_dup   <= res_idx[0];
                                lp_an_able <= 1'b1;
                                lp_word    <= base_word(lp_abil[3:0], 2'b00);
                                lp_word_wr <= 1'b1;
                            end else begin
                                st_q <= ST_QUIET;
                            end
                        end else if (pd_multi) begin
                            st_q     <= ST_QUIET;
                            pd_fault <= 1'b1;
                        end else if (pd_single) begin
                            st_q       <= ST_DONE;
                            speed      <= pd_speed;
                            full_dup   <= 1'b0;
                            lp_an_able <= 1'b0;
                            lp_word    <= pd_word;
                            lp_word_wr <= 1'b1;
                        end
                    end
                    ST_QUIET: begin
                        if (brk_expire) st_q <= ST_LISTEN;
                    end
                    ST_DONE: begin
                        if (link_up && !link_ok) st_q <= ST_QUIET;
                    end
                    default: st_q <= ST_LISTEN;
                endcase
            end
        end
    end

    // Link flag: follows link_ok only while completed and not restarting.
    always_ff @(posedge clk) begin
        if (!rst_n) link_up <= 1'b0;
        else        link_up <= (st_q == ST_DONE) && link_ok && !restart_req;
    end

    // Local base word register for the outgoing page.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_base_word <= 16'h0000;
        else        tx_base_word <= base_word(adv_abil[3:0], adv_pause);
    end

    // R6
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> tx_quiet);

    // R8
    link_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |-> an_done);

    // R8
    link_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |-> $past(link_ok));

    // R4
    pd_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(an_done) && !lp_an_able) |-> !full_dup);

    // R4
    pd_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(an_done) && !lp_an_able) |-> (lp_word[4:0] == 5'b00001));

    // R3
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lp_word_wr |-> $rose(an_done));

    // R7
    loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && !link_ok) |=> (tx_quiet && !link_up));
endmodule

// File: tb/sim_an_resolve_ctrl.sv
module sim_an_resolve_ctrl;
    localparam int PERIOD = 10;
    localparam int TDIV   = 4;
    localparam int QMS    = 3;
    localparam int NV     = 8;

    // Vector: adv[15:10] lp[9:4] ok[3] speed[2:1] full[0]
    localparam logic [15:0] VECS [NV] = '{
        {6'h3F, 6'h3F, 1'b1, 2'd2, 1'b1},
        {6'h3F, 6'h10, 1'b1, 2'd2, 1'b0},
        {6'h3F, 6'h0C, 1'b1, 2'd1, 1'b1},
        {6'h0F, 6'h30, 1'b0, 2'd0, 1'b0},
        {6'h2A, 6'h15, 1'b0, 2'd0, 1'b0},
        {6'h07, 6'h3D, 1'b1, 2'd1, 1'b0},
        {6'h01, 6'h3F, 1'b1, 2'd0, 1'b0},
        {6'h03, 6'h02, 1'b1, 2'd0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  adv_abil = '0;
    logic [1:0]  adv_pause = '0;
    logic [5:0]  lp_abil = '0;
    logic        lp_valid = 1'b0, pd_link10 = 1'b0, pd_link100 = 1'b0;
    logic        link_ok = 1'b0, restart_req = 1'b0;
    logic [1:0]  speed;
    logic        full_dup, an_done, link_up, pd_fault, lp_an_able, lp_word_wr, tx_quiet;
    logic [15:0] lp_word, tx_base_word;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    an_resolve_ctrl #(.TICK_DIV(TDIV), .QUIET_MS(QMS)) u0 (
        .clk(clk), .rst_n(rst_n), .adv_abil(adv_abil), .adv_pause(adv_pause),
        .lp_abil(lp_abil), .lp_valid(lp_valid), .pd_link10(pd_link10),
        .pd_link100(pd_link100), .link_ok(link_ok), .restart_req(restart_req),
        .speed(speed), .full_dup(full_dup), .an_done(an_done), .link_up(link_up),
        .pd_fault(pd_fault), .lp_an_able(lp_an_able), .lp_word(lp_word),
        .lp_word_wr(lp_word_wr), .tx_base_word(tx_base_word), .tx_quiet(tx_quiet)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic pulse_restart();
        @(negedge clk); restart_req = 1'b1;
        step();
        @(negedge clk); restart_req = 1'b0;
    endtask

    task automatic wait_listen();
        for (int k = 0; k < 200 && tx_quiet; k++) step();
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            nerr++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int qcnt;
        // R10 reset state
        step(); step();
        chk("R10 an_done", an_done, 0);
        chk("R10 tx_quiet", tx_quiet, 0);
        chk("R10 link_up", link_up, 0);
        chk("R10 pd_fault", pd_fault, 0);
        chk("R10 lp_word_wr", lp_word_wr, 0);
        @(negedge clk);
        rst_n = 1'b1; adv_abil = 6'h2F; adv_pause = 2'b10;
        step();
        chk("R9 tx_base_word", tx_base_word, 16'h09E1);

        // R1 R2 R3 vector table
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            adv_abil = VECS[v][15:10]; lp_abil = VECS[v][9:4]; lp_valid = 1'b1;
            step();
            @(negedge clk); lp_valid = 1'b0;
            if (VECS[v][3]) begin
                chk("R1 an_done", an_done, 1);
                chk("R1 speed", speed, VECS[v][2:1]);
                chk("R1 full_dup", full_dup, VECS[v][0]);
                chk("R3 lp_an_able", lp_an_able, 1);
                chk("R3 lp_word_wr", lp_word_wr, 1);
                chk("R3 lp_word", lp_word, {7'b0, VECS[v][7:4], 5'b00001});
                pulse_restart();
            end else begin
                chk("R2 an_done", an_done, 0);
                chk("R2 tx_quiet", tx_quiet, 1);
            end
            wait_listen();
        end

        // R8 link ignored while listening
        @(negedge clk); link_ok = 1'b1;
        step(); step();
        chk("R8 link_up listen", link_up, 0);
        @(negedge clk); link_ok = 1'b0;

        // R4 parallel detect at 10
        @(negedge clk); pd_link10 = 1'b1;
        step();
        chk("R4 an_done", an_done, 1);
        chk("R4 speed10", speed, 0);
        chk("R4 half", full_dup, 0);
        chk("R4 lp_an_able", lp_an_able, 0);
        chk("R4 lp_word10", lp_word, 16'h0021);
        // R8 link rises one clock after link_ok
        @(negedge clk); link_ok = 1'b1;
        step();
        chk("R8 link_up", link_up, 1);
        // R7 link loss
        @(negedge clk); link_ok = 1'b0; pd_link10 = 1'b0;
        step();
        chk("R7 link_up", link_up, 0);
        chk("R7 tx_quiet", tx_quiet, 1);
        chk("R7 an_done", an_done, 0);
        wait_listen();

        // R11 negotiated result wins over parallel detect
        @(negedge clk);
        adv_abil = 6'h3F; lp_abil = 6'h3F; lp_valid = 1'b1; pd_link100 = 1'b1;
        step();
        @(negedge clk); lp_valid = 1'b0; pd_link100 = 1'b0;
        chk("R11 speed", speed, 2);
        chk("R11 lp_an_able", lp_an_able, 1);
        pulse_restart();
        wait_listen();

        // R4 parallel detect at 100
        @(negedge clk); pd_link100 = 1'b1;
        step();
        @(negedge clk); pd_link100 = 1'b0;
        chk("R4 speed100", speed, 1);
        chk("R4 lp_word100", lp_word, 16'h0081);
        pulse_restart();
        wait_listen();

        // R5 fault on two links, sticky
        @(negedge clk); pd_link10 = 1'b1; pd_link100 = 1'b1;
        step();
        @(negedge clk); pd_link10 = 1'b0; pd_link100 = 1'b0;
        chk("R5 pd_fault", pd_fault, 1);
        chk("R5 tx_quiet", tx_quiet, 1);
        wait_listen();
        step();
        chk("R5 sticky", pd_fault, 1);

        // R6 restart: clears fault, exact silent length
        @(negedge clk); restart_req = 1'b1;
        step();
        @(negedge clk); restart_req = 1'b0;
        chk("R5 cleared", pd_fault, 0);
        qcnt = 0;
        for (int k = 0; k < 200 && tx_quiet; k++) begin
            qcnt++;
            step();
        end
        chk("R6 quiet length", qcnt, TDIV * QMS);
        chk("R6 an_done", an_done, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule